// File: doc/BRIEF.md
# PCM TDM Serial Port with Frame-Sync Width Detection

This block is the digital serial side of a full-duplex telephony codec. Once per 8 kHz frame it sends one 8-bit companded sample on a transmit data line and collects one 8-bit sample from a receive data line. Each direction has its own bit clock and frame-sync input. All of these inputs are oversampled by a fast system clock through synchronizer chains and turned into edge pulses, so the whole block runs in a single clock domain.

The width of each sync pulse is measured in falling bit-clock edges. That width chooses short or long framing for the next timeslot in the same direction. Short framing waits one bit period after the sync is captured. Long framing starts on the later of the sync rise and the bit-clock rise. The transmit side drives a data-enable for an external tri-state buffer and an active-low timeslot strobe. A receive-side master-clock input that stays high with no falling edge for a set number of system cycles puts the port into power-down. The first falling edge on that input brings it back.

Top module: `pcm_tdm_port`

## Requirements
- R1: A sync pulse that covers 1 to SHORT_MAX (default 2) falling bit-clock edges selects short framing for the next timeslot of that direction. A pulse covering SHORT_MAX+1 to LONG_MAX (default 8) edges selects long framing. Any other count (0 or above LONG_MAX) keeps the previous mode. After reset the mode is short, or long if RESET_LONG=1. A slot keeps the mode that was valid at its sync rise.
- R2: In short framing, the first bit is launched on the first bit-clock rising edge after the first bit-clock falling edge that follows the sync rise. The remaining bits follow on the next rising edges, one bit per edge.
- R3: In long framing, the first bit is launched at the sync rise if the bit clock is high at that moment. If the bit clock is low, the first bit is launched at the next bit-clock rising edge. The remaining bits follow on the next rising edges.
- R4: Bits leave MSB first. The word sent in a slot is the content of a holding register at the slot start. A `tx_load` pulse copies `tx_word` into that register at any time, including during power-down. With no new load, the previous word is sent again.
- R5: `dx_oe` is 1 only while a transmit slot is in progress. It returns to 0 on the first bit-clock falling edge after the last bit was launched. While `dx_oe` stays 1, `dx_o` changes only after a transmit bit-clock rising edge. After reset `dx_oe` is 0.
- R6: `tsx_n` is 0 exactly while `dx_oe` is 1, and 1 otherwise, including after reset.
- R7: Receive data is sampled on bit-clock falling edges, MSB first. In short framing the falling edge that captures the sync is skipped. In long framing the first falling edge after the sync rise takes the MSB. After the 8th bit, `rx_word` holds the word and `rx_valid` is 1 for exactly one cycle.
- R8: `pd_o` goes to 1 once `mclk_rx` has been high with no falling edge for PD_CYCLES_SEL0 system cycles when `clk_sel`=0, or PD_CYCLES_SEL1 cycles when `clk_sel`=1. It returns to 0 after the first falling edge of `mclk_rx`. An `mclk_rx` held low never causes power-down.
- R9: While `pd_o` is 1, no slot is produced: `dx_oe` stays 0, `tsx_n` stays 1 and `rx_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_tx | input | 1 | Transmit bit clock |
| fs_tx | input | 1 | Transmit frame sync |
| bclk_rx | input | 1 | Receive bit clock |
| fs_rx | input | 1 | Receive frame sync |
| mclk_rx | input | 1 | Receive master clock, monitored for power-down |
| clk_sel | input | 1 | Master-clock rate select; picks the power-down timeout |
| tx_word | input | WORD_W | Next word to transmit |
| tx_load | input | 1 | Copies tx_word into the holding register |
| dr_i | input | 1 | Receive serial data |
| dx_o | output | 1 | Transmit serial data |
| dx_oe | output | 1 | Enable for the external tri-state driver of dx_o |
| tsx_n | output | 1 | Timeslot strobe, active low |
| rx_word | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is new |
| pd_o | output | 1 | Power-down indication |

## Verification
A wrong framing mode shows up right away: the whole transmit word moves by one bit period, which corrupts every bit check and the looped-back receive word in that same frame. A wrong bit counter or shift register shows at the ports within one bit period, as a wrong data bit, or as `dx_oe`/`tsx_n` releasing too early or too late. A power-down counter with the wrong limit or reset condition makes `pd_o` change before or after the boundary window, and the frame that follows shows slot activity that should not be there.

// File: rtl/pcm_tdm_pkg.sv
`timescale 1ns/1ps
package pcm_tdm_pkg;
   typedef enum logic {FRM_SHORT = 1'b0, FRM_LONG = 1'b1} frame_mode_e;
   typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_WAIT, TX_SHIFT} tx_state_e;
   typedef enum logic [1:0] {RX_IDLE, RX_SKIP, RX_CAPT} rx_state_e;
endpackage

// File: rtl/pcm_edge_sync.sv
`timescale 1ns/1ps
// Synchronizer chain followed by edge detection on the last stage.
module pcm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcm_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '0;
         prev <= 1'b0;
      end else begin
         pipe <= {pipe[STAGES-2:0], din};
         prev <= pipe[STAGES-1];
      end
   end

   assign lvl  = pipe[STAGES-1];
   assign rise = pipe[STAGES-1] & ~prev;
   assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/pcm_frame_meter.sv
`timescale 1ns/1ps
// Counts falling bit-clock edges under the sync pulse and picks the framing.
module pcm_frame_meter
   import pcm_tdm_pkg::*;
#(
   parameter int SHORT_MAX  = 2,
   parameter int LONG_MAX   = 8,
   parameter bit RESET_LONG = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fs_lvl,
   input  logic        fs_rise,
   input  logic        fs_fall,
   input  logic        bclk_fall,
   output frame_mode_e mode
);
   localparam int CW = $clog2(LONG_MAX + 2);
   localparam logic [CW-1:0] SAT  = CW'(LONG_MAX + 1);
   localparam logic [CW-1:0] SMAX = CW'(SHORT_MAX);
   localparam logic [CW-1:0] LMAX = CW'(LONG_MAX);
   localparam frame_mode_e   MODE_AT_RESET = RESET_LONG ? FRM_LONG : FRM_SHORT;

   logic [CW-1:0] width_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q <= '0;
      end else if (fs_rise) begin
         width_q <= '0;
      end else if (fs_lvl && bclk_fall && (width_q != SAT)) begin
         width_q <= width_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MODE_AT_RESET;
      end else if (fs_fall) begin
         if ((width_q != '0) && (width_q <= SMAX)) begin
            mode <= FRM_SHORT;
         end else if ((width_q > SMAX) && (width_q <= LMAX)) begin
            mode <= FRM_LONG;
         end
      end
   end
endmodule

// File: rtl/pcm_tx_lane.sv
`timescale 1ns/1ps
// Transmit timeslot sequencer and shift register.
module pcm_tx_lane
   import pcm_tdm_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd,
   input  logic              fs_rise,
   input  logic              bclk_lvl,
   input  logic              bclk_rise,
   input  logic              bclk_fall,
   input  frame_mode_e       mode,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   output logic              dx,
   output logic              active
);
   localparam int NW = $clog2(WORD_W + 1);
   localparam logic [NW-1:0] LAST = NW'(WORD_W);

   tx_state_e         state;
   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] sh_q;
   logic [NW-1:0]     nsent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (load) begin
         hold_q <= word_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= TX_IDLE;
         sh_q    <= '0;
         nsent_q <= '0;
      end else if (pd) begin
         state   <= TX_IDLE;
         nsent_q <= '0;
      end else begin
         case (state)
            TX_IDLE: begin
               if (fs_rise) begin
                  if (mode == FRM_LONG) begin
                     if (bclk_lvl) begin
                        sh_q    <= hold_q;
                        nsent_q <= NW'(1);
                        state   <= TX_SHIFT;
                     end else begin
                        state <= TX_WAIT;
                     end
                  end else begin
                     state <= TX_ARM;
                  end
               end
            end
            TX_ARM: begin
               if (bclk_fall) state <= TX_WAIT;
            end
            TX_WAIT: begin
               if (bclk_rise) begin
                  sh_q    <= hold_q;
                  nsent_q <= NW'(1);
                  state   <= TX_SHIFT;
               end
            end
            TX_SHIFT: begin
               if (bclk_fall && (nsent_q == LAST)) begin
                  state   <= TX_IDLE;
                  nsent_q <= '0;
               end else if (bclk_rise && (nsent_q != LAST)) begin
                  sh_q    <= {sh_q[WORD_W-2:0], 1'b0};
                  nsent_q <= nsent_q + 1'b1;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   assign active = (state == TX_SHIFT);
   assign dx     = active & sh_q[WORD_W-1];
endmodule

// File: rtl/pcm_rx_lane.sv
`timescale 1ns/1ps
// Receive timeslot sequencer and deserializer.
module pcm_rx_lane
   import pcm_tdm_pkg::*;
#(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd,
   input  logic              fs_rise,
   input  logic              bclk_fall,
   input  frame_mode_e       mode,
   input  logic              dr_lvl,
   output logic [WORD_W-1:0] word_out,
   output logic              valid
);
   localparam int NW = $clog2(WORD_W + 1);
   localparam logic [NW-1:0] LAST_IDX = NW'(WORD_W - 1);

   rx_state_e         state;
   logic [WORD_W-1:0] sh_q;
   logic [NW-1:0]     nrecv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         sh_q     <= '0;
         nrecv_q  <= '0;
         word_out <= '0;
         valid    <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (pd) begin
            state   <= RX_IDLE;
            nrecv_q <= '0;
         end else begin
            case (state)
               RX_IDLE: begin
                  if (fs_rise) begin
                     nrecv_q <= '0;
                     state   <= (mode == FRM_LONG) ? RX_CAPT : RX_SKIP;
                  end
               end
               RX_SKIP: begin
                  if (bclk_fall) state <= RX_CAPT;
               end
               RX_CAPT: begin
                  if (bclk_fall) begin
                     sh_q <= {sh_q[WORD_W-2:0], dr_lvl};
                     if (nrecv_q == LAST_IDX) begin
                        word_out <= {sh_q[WORD_W-2:0], dr_lvl};
                        valid    <= 1'b1;
                        nrecv_q  <= '0;
                        state    <= RX_IDLE;
                     end else begin
                        nrecv_q <= nrecv_q + 1'b1;
                     end
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/pcm_pd_detect.sv
`timescale 1ns/1ps
// Declares power-down when the monitored clock sits high without a falling edge.
module pcm_pd_detect #(
   parameter int PD_CYCLES_SEL0 = 2048,
   parameter int PD_CYCLES_SEL1 = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic mon_lvl,
   input  logic mon_fall,
   output logic pd
);
   localparam int PD_MAX = (PD_CYCLES_SEL0 > PD_CYCLES_SEL1) ? PD_CYCLES_SEL0 : PD_CYCLES_SEL1;
   localparam int PW     = $clog2(PD_MAX + 1);
   localparam logic [PW-1:0] LIM0 = PW'(PD_CYCLES_SEL0 - 1);
   localparam logic [PW-1:0] LIM1 = PW'(PD_CYCLES_SEL1 - 1);

   logic [PW-1:0] quiet_q;
   logic [PW-1:0] limit;

   assign limit = sel ? LIM1 : LIM0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= '0;
         pd      <= 1'b0;
      end else if (mon_fall || !mon_lvl) begin
         quiet_q <= '0;
         pd      <= 1'b0;
      end else if (quiet_q >= limit) begin
         pd <= 1'b1;
      end else begin
         quiet_q <= quiet_q + 1'b1;
      end
   end
endmodule

// File: rtl/pcm_tdm_port.sv
`timescale 1ns/1ps
// PCM TDM serial port: oversampled inputs, framing detection, tx/rx lanes.
module pcm_tdm_port
   import pcm_tdm_pkg::*;
#(
   parameter int WORD_W         = 8,
   parameter int SYNC_STAGES    = 2,
   parameter int SHORT_MAX      = 2,
   parameter int LONG_MAX       = 8,
   parameter bit RESET_LONG     = 1'b0,
   parameter int PD_CYCLES_SEL0 = 2048,
   parameter int PD_CYCLES_SEL1 = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_tx,
   input  logic              fs_tx,
   input  logic              bclk_rx,
   input  logic              fs_rx,
   input  logic              mclk_rx,
   input  logic              clk_sel,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tx_load,
   input  logic              dr_i,
   output logic              dx_o,
   output logic              dx_oe,
   output logic              tsx_n,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_valid,
   output logic              pd_o
);
   localparam int N_IN    = 6;
   localparam int IDX_BTX = 0;
   localparam int IDX_FTX = 1;
   localparam int IDX_BRX = 2;
   localparam int IDX_FRX = 3;
   localparam int IDX_DR  = 4;
   localparam int IDX_MCK = 5;
   localparam int N_DIR   = 2;

   if (WORD_W < 2) begin : g_bad_word
      $error("pcm_tdm_port: WORD_W must be at least 2");
   end
   if ((SHORT_MAX < 1) || (LONG_MAX <= SHORT_MAX)) begin : g_bad_frame
      $error("pcm_tdm_port: need 1 <= SHORT_MAX < LONG_MAX");
   end
   if ((PD_CYCLES_SEL0 < 2) || (PD_CYCLES_SEL1 < 2)) begin : g_bad_pd
      $error("pcm_tdm_port: power-down limits must be at least 2");
   end

   logic [N_IN-1:0] raw_v;
   logic [N_IN-1:0] lvl_v;
   logic [N_IN-1:0] rise_v;
   logic [N_IN-1:0] fall_v;

   assign raw_v = {mclk_rx, dr_i, fs_rx, bclk_rx, fs_tx, bclk_tx};

   for (genvar i = 0; i < N_IN; i++) begin : g_sync
      pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_v[i]),
         .lvl  (lvl_v[i]),
         .rise (rise_v[i]),
         .fall (fall_v[i])
      );
   end

   // Direction k uses bit clock at index 2k and frame sync at index 2k+1.
   frame_mode_e mode_v [N_DIR];

   for (genvar k = 0; k < N_DIR; k++) begin : g_meter
      pcm_frame_meter #(
         .SHORT_MAX (SHORT_MAX),
         .LONG_MAX  (LONG_MAX),
         .RESET_LONG(RESET_LONG)
      ) u_meter (
         .clk      (clk),
         .rst_n    (rst_n),
         .fs_lvl   (lvl_v[2*k+1]),
         .fs_rise  (rise_v[2*k+1]),
         .fs_fall  (fall_v[2*k+1]),
         .bclk_fall(fall_v[2*k]),
         .mode     (mode_v[k])
      );
   end

   logic btx_rise, btx_fall, mck_lvl, mck_fall, tx_active;

   assign btx_rise = rise_v[IDX_BTX];
   assign btx_fall = fall_v[IDX_BTX];
   assign mck_lvl  = lvl_v[IDX_MCK];
   assign mck_fall = fall_v[IDX_MCK];

   logic unused_edges;
   assign unused_edges = ^{lvl_v[IDX_BRX], rise_v[IDX_BRX], rise_v[IDX_DR],
                           fall_v[IDX_DR], rise_v[IDX_MCK], lvl_v[IDX_FTX] & 1'b0};

   pcm_pd_detect #(
      .PD_CYCLES_SEL0(PD_CYCLES_SEL0),
      .PD_CYCLES_SEL1(PD_CYCLES_SEL1)
   ) u_pd (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (clk_sel),
      .mon_lvl (mck_lvl),
      .mon_fall(mck_fall),
      .pd      (pd_o)
   );

   pcm_tx_lane #(.WORD_W(WORD_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd       (pd_o),
      .fs_rise  (rise_v[IDX_FTX]),
      .bclk_lvl (lvl_v[IDX_BTX]),
      .bclk_rise(btx_rise),
      .bclk_fall(btx_fall),
      .mode     (mode_v[0]),
      .load     (tx_load),
      .word_in  (tx_word),
      .dx       (dx_o),
      .active   (tx_active)
   );

   assign dx_oe = tx_active;
   assign tsx_n = ~tx_active;

   pcm_rx_lane #(.WORD_W(WORD_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd       (pd_o),
      .fs_rise  (rise_v[IDX_FRX]),
      .bclk_fall(fall_v[IDX_BRX]),
      .mode     (mode_v[1]),
      .dr_lvl   (lvl_v[IDX_DR]),
      .word_out (rx_word),
      .valid    (rx_valid)
   );
endmodule

// File: rtl/pcm_tdm_port_chk.sv
`timescale 1ns/1ps
// Temporal checks on the port, attached through bind.
module pcm_tdm_port_chk (
   input logic clk,
   input logic rst_n,
   input logic dx_o,
   input logic dx_oe,
   input logic rx_valid,
   input logic pd_o,
   input logic btx_rise,
   input logic btx_fall,
   input logic mck_lvl,
   input logic mck_fall
);
   assert_quiet_in_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_o && $past(pd_o)) |-> (!dx_oe && !rx_valid));

   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_release_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dx_oe) |-> ($past(btx_fall) || $past(pd_o)));

   assert_data_moves_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dx_oe && $past(dx_oe) && !$past(btx_rise)) |-> $stable(dx_o));

   assert_pd_needs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_o) |-> $past(mck_lvl));

   assert_pd_exit_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pd_o) |-> ($past(mck_fall) || !$past(mck_lvl)));
endmodule

bind pcm_tdm_port pcm_tdm_port_chk chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .dx_o    (dx_o),
   .dx_oe   (dx_oe),
   .rx_valid(rx_valid),
   .pd_o    (pd_o),
   .btx_rise(btx_rise),
   .btx_fall(btx_fall),
   .mck_lvl (mck_lvl),
   .mck_fall(mck_fall)
);

// File: tb/pcm_tdm_port_tb_top.sv
`timescale 1ns/1ps
module pcm_tdm_port_tb_top;
   localparam int W    = 8;
   localparam int PD0  = 100;
   localparam int PD1  = 200;
   localparam int HALF = 10;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n, bclk, fs, mclk_rx, clk_sel, tx_load;
   logic [W-1:0] tx_word;
   logic         dr_i, dx_o, dx_oe, tsx_n, rx_valid, pd_o;
   logic [W-1:0] rx_word;

   assign dr_i = dx_oe ? dx_o : 1'b1;

   pcm_tdm_port #(
      .WORD_W(W), .PD_CYCLES_SEL0(PD0), .PD_CYCLES_SEL1(PD1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .bclk_tx(bclk), .fs_tx(fs),
      .bclk_rx(bclk), .fs_rx(fs), .mclk_rx(mclk_rx), .clk_sel(clk_sel),
      .tx_word(tx_word), .tx_load(tx_load), .dr_i(dr_i), .dx_o(dx_o),
      .dx_oe(dx_oe), .tsx_n(tsx_n), .rx_word(rx_word), .rx_valid(rx_valid),
      .pd_o(pd_o)
   );

   int checks = 0;
   int failures = 0;
   int rx_cnt = 0;
   logic [W-1:0] rx_last = '0;
   bit exp_long;
   logic [W-1:0] hold_w;

   always @(negedge clk) begin
      if (rx_valid) begin
         rx_cnt  <= rx_cnt + 1;
         rx_last <= rx_word;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // One frame: periods -1..11 of 2*HALF clk cycles, bit clock high first.
   task automatic run_frame(input logic [W-1:0] word, input bit do_load,
                            input int width, input bit low_rise, input bit in_pd);
      logic [W-1:0] sent;
      int first;
      int cnt0;
      string btag;
      sent  = do_load ? word : hold_w;
      if (do_load) hold_w = word;
      first = exp_long ? 0 : 1;
      btag  = exp_long ? "R1 R3 R4 long-frame bit" : "R1 R2 R4 short-frame bit";
      cnt0  = rx_cnt;
      for (int p = -1; p <= 11; p++) begin
         for (int c = 0; c < 2*HALF; c++) begin
            @(negedge clk);
            if (c == HALF-1) begin
               if (in_pd) begin
                  chk(dx_oe === 1'b0 && tsx_n === 1'b1, "R9 slot suppressed",
                      int'(dx_oe), 0);
               end else if (p >= first && p < first + W) begin
                  chk(dx_oe === 1'b1, "R5 enable in slot", int'(dx_oe), 1);
                  chk(tsx_n === 1'b0, "R6 strobe low in slot", int'(tsx_n), 0);
                  chk(dx_o === sent[W-1-(p-first)], btag, int'(dx_o),
                      int'(sent[W-1-(p-first)]));
               end
            end
            if (c == 2*HALF-1 && !in_pd) begin
               if (p == first + W - 1)
                  chk(dx_oe === 1'b0 && tsx_n === 1'b1, "R5 R6 release after last bit",
                      int'(dx_oe), 0);
               if (!exp_long && p == 0)
                  chk(dx_oe === 1'b0, "R2 no launch before capture", int'(dx_oe), 0);
               if (exp_long && low_rise && p == -1)
                  chk(dx_oe === 1'b0, "R3 waits for bit-clock rise", int'(dx_oe), 0);
            end
            bclk    = (c < HALF);
            tx_load = do_load && p == -1 && c == 0;
            if (tx_load) tx_word = word;
            if ((low_rise && p == -1 && c == HALF+2) || (!low_rise && p == 0 && c == 2))
               fs = 1'b1;
            if ((width == 0 && p == 0 && c == 6) || (width > 0 && p == width && c == 2))
               fs = 1'b0;
         end
      end
      if (in_pd) begin
         chk(rx_cnt == cnt0, "R9 no receive word", rx_cnt - cnt0, 0);
      end else begin
         chk(rx_cnt == cnt0 + 1, "R7 one receive word", rx_cnt - cnt0, 1);
         chk(rx_last == sent, "R7 loopback word", int'(rx_last), int'(sent));
      end
      if (width >= 1 && width <= 2) exp_long = 1'b0;
      else if (width >= 3 && width <= 8) exp_long = 1'b1;
   endtask

   task automatic pd_boundary(input bit sel, input int lim);
      clk_sel = sel;
      mclk_rx = 1'b1;
      repeat (lim - 12) @(negedge clk);
      chk(pd_o === 1'b0, "R8 not before limit", int'(pd_o), 0);
      repeat (24) @(negedge clk);
      chk(pd_o === 1'b1, "R8 asserted after limit", int'(pd_o), 1);
   endtask

   initial begin
      rst_n = 1'b0; bclk = 1'b0; fs = 1'b0; mclk_rx = 1'b0; clk_sel = 1'b0;
      tx_word = '0; tx_load = 1'b0; exp_long = 1'b0; hold_w = '0;
      repeat (5) @(negedge clk);
      chk(dx_oe === 1'b0, "R5 reset enable", int'(dx_oe), 0);
      chk(tsx_n === 1'b1, "R6 reset strobe", int'(tsx_n), 1);
      chk(rx_valid === 1'b0 && pd_o === 1'b0, "R7 R8 reset outputs", int'(pd_o), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // Directed framing cases (mode of each frame set by the one before).
      run_frame(8'h81, 1'b1, 1,  1'b0, 1'b0);
      run_frame(8'h3C, 1'b1, 5,  1'b0, 1'b0);
      run_frame(8'hC3, 1'b1, 2,  1'b0, 1'b0);
      run_frame(8'h5A, 1'b1, 8,  1'b1, 1'b0);
      run_frame(8'h96, 1'b0, 0,  1'b1, 1'b0);  // R4 resend, R1 width 0 keeps long
      run_frame(8'h11, 1'b1, 10, 1'b0, 1'b0);  // R1 width above limit keeps long
      run_frame(8'h22, 1'b1, 3,  1'b1, 1'b0);

      // Sweep every word value across widths, sync phases and load patterns.
      for (int i = 0; i < 256; i++) begin
         run_frame(W'(i), (i % 5) != 2, i % 11, ((i / 11) % 2) == 1, 1'b0);
      end

      // Power-down with each clock selection.
      pd_boundary(1'b0, PD0);
      run_frame(8'hE7, 1'b1, 4, 1'b0, 1'b1);
      mclk_rx = 1'b0;
      repeat (6) @(negedge clk);
      chk(pd_o === 1'b0, "R8 cleared by falling edge", int'(pd_o), 0);
      run_frame(8'h7E, 1'b1, 2, 1'b0, 1'b0);
      pd_boundary(1'b1, PD1);
      run_frame(8'h0F, 1'b0, 6, 1'b1, 1'b1);
      mclk_rx = 1'b0;
      repeat (6) @(negedge clk);
      chk(pd_o === 1'b0, "R8 cleared by falling edge sel1", int'(pd_o), 0);
      run_frame(8'hA4, 1'b1, 1, 1'b0, 1'b0);
      run_frame(8'h00, 1'b0, 7, 1'b0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule